// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip host and an external asynchronous byte-wide static RAM. The host posts one read or one write at a time on a valid/ready port. The block sequences the RAM control lines so that every interval the memory needs is met. Those lines are an active-low select, an active-high select, an active-low output enable and an active-low write enable. It also drives the data-bus output enable for the pad tristate. When the access is finished, the block returns a one-cycle acknowledge together with the read data.

All strobe widths, setup windows and turnaround gaps are counted in clock cycles. Each count is fixed at elaboration from a clock-period parameter and a set of nanosecond timing parameters. The rounding is upward: ceil(t/period), never less than 1. The memory counts as selected only while the low select is low and the high select is high. Writes are framed by the write enable: both selects stay active for the whole access, and the write window is the stretch in which write enable is low.

Each access passes through four states: idle, setup, strobe and recover. A faster or slower memory grade is supported by changing only the nanosecond parameters.

Top module: `asram_ctrl`

## Requirements
- R1: On synchronous active-low reset the block drives mem_sel_n=1, mem_sel=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and rsp_valid=0, and req_ready=1 after reset.
- R2: req_ready is high only while no access is in progress. A request is taken on a clock edge where req_valid and req_ready are both high. Address, write data and direction (req_write=1 means write) are captured at that edge, and a request held valid while the block is busy is taken only once.
- R3: The two selects always agree: either the memory is selected (mem_sel_n=0, mem_sel=1) or it is deselected (mem_sel_n=1, mem_sel=0). The memory is selected during the setup and strobe phases of an access and deselected otherwise.
- R4: A write holds mem_we_n low for N_WSTB = max(ceil(tWP), ceil(tCW)-1, ceil(tAW)-1, ceil(tWHZ)+ceil(tDW)) cycles, which is 9 cycles with the defaults at 5 ns. mem_oe_n stays high for the whole write access.
- R5: mem_dq_oe is high only while mem_we_n is low. It rises only after ceil(tWHZ) cycles of mem_we_n low (4 cycles) and falls on the edge that raises mem_we_n, which gives N_WSTB-ceil(tWHZ) driven cycles (5 cycles ≥ ceil(tDW)). The byte written to the memory is the captured write data.
- R6: A read holds mem_oe_n low with mem_we_n high for N_RSTB = max(ceil(tOE), ceil(tAA)-1) cycles (10 cycles). The data is captured on the final strobe cycle and returned on rsp_rdata.
- R7: After the strobe, the block waits in recover for max(1, ceil(tWC)-1-N_WSTB) cycles after a write (1 cycle) or max(ceil(tHZ), ceil(tRC)-1-N_RSTB, 1) cycles after a read (4 cycles) before req_ready rises again.
- R8: rsp_valid is a single-cycle pulse for every accepted request. It is high in the cycle after the last strobe cycle, which is 10 cycles after the accept edge for a write and 11 cycles after it for a read with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid |
| mem_addr | output | 18 | Memory address lines |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Pad tristate enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned from the memory pads |

## Verification
The assertions assume that req_valid, req_write, req_addr and req_wdata do not change between clock edges. They also assume that mem_dq_in is settled by the edge on which the block captures it. The bench drives every host input on the falling edge. Its memory model updates the returned byte on the falling edge too. That model returns a poison value until the select has been active for 11 cycles and the output enable low for 5 cycles. As a result, a strobe that is too short shows up as a data miscompare rather than as a race.

// File: rtl/asram_pkg.sv
// Shared types and elaboration-time helpers for the static RAM sequencer.
// Assumes all timing parameters are positive integers in nanoseconds.
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } acc_state_e;

    // Round a nanosecond interval up to whole clock cycles, at least one.
    function automatic int ns2cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_interval_timer.sv
// Down-counter that times each phase of an access.
// Loading N gives N cycles in the phase; last_o marks the final one.
// Assumes load is only pulsed on a phase change.
module asram_interval_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/asram_seq.sv
// Access sequencer: walks idle -> setup -> strobe -> recover and decodes
// the memory control strobes from the phase and the phase timer.
// Assumes req_fire is a single-cycle acceptance qualified by ready_o.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int N_WSTB = 9,
    parameter int N_RSTB = 10,
    parameter int N_WREC = 1,
    parameter int N_RREC = 4,
    parameter int N_WHZ  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_fire,
    input  logic req_write,
    output logic ready_o,
    output logic sel_act_o,
    output logic we_n_o,
    output logic oe_n_o,
    output logic dq_oe_o,
    output logic cap_en_o,
    output logic ack_set_o
);
    localparam logic [CNT_W-1:0] DQ_ON_AT = CNT_W'(N_WSTB - N_WHZ);

    acc_state_e       st_q, st_d;
    logic             wr_q;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] cnt;
    logic             last;

    asram_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .cnt_o    (cnt),
        .last_o   (last)
    );

    // Phase transitions and the length of the phase being entered.
    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_val = '0;
        case (st_q)
            ST_IDLE: if (req_fire) begin
                st_d = ST_SETUP; ld = 1'b1; ld_val = CNT_W'(1);
            end
            ST_SETUP: if (last) begin
                st_d = ST_STROBE; ld = 1'b1;
                ld_val = wr_q ? CNT_W'(N_WSTB) : CNT_W'(N_RSTB);
            end
            ST_STROBE: if (last) begin
                st_d = ST_RECOVER; ld = 1'b1;
                ld_val = wr_q ? CNT_W'(N_WREC) : CNT_W'(N_RREC);
            end
            ST_RECOVER: if (last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase register and latched access direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            wr_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (req_fire) wr_q <= req_write;
        end
    end

    // Strobe decode from phase, direction and remaining phase cycles.
    always_comb begin
        ready_o   = (st_q == ST_IDLE);
        sel_act_o = (st_q == ST_SETUP) || (st_q == ST_STROBE);
        we_n_o    = !((st_q == ST_STROBE) && wr_q);
        oe_n_o    = !((st_q == ST_STROBE) && !wr_q);
        dq_oe_o   = (st_q == ST_STROBE) && wr_q && (cnt <= DQ_ON_AT);
        ack_set_o = (st_q == ST_STROBE) && last;
        cap_en_o  = ack_set_o && !wr_q;
    end

    // R3
    we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> sel_act_o);
    // R5
    dq_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> !we_n_o);
    // R5
    dq_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe_o) |-> $past(!we_n_o));
    // R6
    oe_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> (we_n_o && sel_act_o));
    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (we_n_o && oe_n_o && !sel_act_o && !dq_oe_o));
    // R7
    we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> !ready_o);

endmodule

// File: rtl/asram_datapath.sv
// Address/data holding registers, read capture and completion pulse.
// Assumes cap_en and ack_set come from the sequencer's last strobe cycle.
module asram_datapath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cap_en,
    input  logic              ack_set,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid
);
    // Hold address and write data for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (req_fire) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Capture read data before output enable is released; raise the ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= ack_set;
            if (cap_en) rsp_rdata <= mem_dq_in;
        end
    end

    // R2
    addr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_fire) |-> (mem_addr == $past(req_addr)));
    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_ctrl.sv
// Top of the asynchronous static RAM sequencer. Converts the nanosecond
// timing parameters to cycle counts and joins sequencer and datapath.
// Assumes a single outstanding request and a free-running clock.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 5,
    parameter int T_WC   = 55,
    parameter int T_CW   = 45,
    parameter int T_AW   = 45,
    parameter int T_WP   = 40,
    parameter int T_DW   = 25,
    parameter int T_WHZ  = 20,
    parameter int T_RC   = 55,
    parameter int T_AA   = 55,
    parameter int T_OE   = 25,
    parameter int T_HZ   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int N_WC   = ns2cyc(T_WC,  CLK_NS);
    localparam int N_CW   = ns2cyc(T_CW,  CLK_NS);
    localparam int N_AW   = ns2cyc(T_AW,  CLK_NS);
    localparam int N_WP   = ns2cyc(T_WP,  CLK_NS);
    localparam int N_DW   = ns2cyc(T_DW,  CLK_NS);
    localparam int N_WHZ  = ns2cyc(T_WHZ, CLK_NS);
    localparam int N_RC   = ns2cyc(T_RC,  CLK_NS);
    localparam int N_AA   = ns2cyc(T_AA,  CLK_NS);
    localparam int N_OE   = ns2cyc(T_OE,  CLK_NS);
    localparam int N_HZ   = ns2cyc(T_HZ,  CLK_NS);
    localparam int N_WSTB = imax(imax(N_WP, N_CW - 1), imax(N_AW - 1, N_WHZ + N_DW));
    localparam int N_WREC = imax(1, N_WC - 1 - N_WSTB);
    localparam int N_RSTB = imax(N_OE, N_AA - 1);
    localparam int N_RREC = imax(imax(1, N_HZ), N_RC - 1 - N_RSTB);
    localparam int N_MAX  = imax(imax(N_WSTB, N_RSTB), imax(N_WREC, N_RREC));
    localparam int CNT_W  = $clog2(N_MAX + 1) + 1;

    logic req_fire;
    logic sel_act;
    logic cap_en;
    logic ack_set;

    assign req_fire  = req_valid && req_ready;
    assign mem_sel_n = !sel_act;
    assign mem_sel   = sel_act;

    asram_seq #(
        .CNT_W  (CNT_W),
        .N_WSTB (N_WSTB),
        .N_RSTB (N_RSTB),
        .N_WREC (N_WREC),
        .N_RREC (N_RREC),
        .N_WHZ  (N_WHZ)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_write (req_write),
        .ready_o   (req_ready),
        .sel_act_o (sel_act),
        .we_n_o    (mem_we_n),
        .oe_n_o    (mem_oe_n),
        .dq_oe_o   (mem_dq_oe),
        .cap_en_o  (cap_en),
        .ack_set_o (ack_set)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cap_en     (cap_en),
        .ack_set    (ack_set),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_rdata  (rsp_rdata),
        .rsp_valid  (rsp_valid)
    );

    // R8
    ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_we_n) || $past(!mem_oe_n)));
    // R3
    sel_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_sel) |-> (mem_we_n && mem_oe_n));

endmodule

// File: tb/asram_ctrl_tb.sv
// Scoreboard bench: driver tasks push expectations, a monitor compares.
module asram_ctrl_tb;
    localparam int CLKP = 5;
    // Cycle counts from the requirements at 5 ns.
    localparam int E_WSTB = 9, E_DQPRE = 4, E_DQON = 5, E_RSTB = 10;
    localparam int E_WREC = 1, E_RREC = 4, E_WLAT = 10, E_RLAT = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hA5;

    int checks = 0, fails = 0, cyc = 0, acks = 0, reqs = 0;
    bit done = 0;

    typedef struct { bit wr; logic [7:0] data; int acc; } exp_t;
    exp_t exp_q[$];
    logic [7:0] gold[int];
    logic [7:0] model_mem[int];

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    always #(CLKP/2.0) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: wait for ready, present one request for one edge, push expectation.
    task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        e.wr = wr; e.acc = cyc + 1;
        if (wr) begin gold[int'(a)] = d; e.data = d; end
        else e.data = gold.exists(int'(a)) ? gold[int'(a)] : 8'hA5;
        exp_q.push_back(e);
        reqs++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Memory model plus bus-timing observers, all on the falling edge.
    bit   wact_q = 0, mixed = 0;
    int   sel_cnt = 0, oe_cnt = 0, we_cnt = 0, dq_cnt = 0, dq_pre = 0, oe_in_wr = 0;
    logic [7:0] last_d = '0;
    int   last_a = 0;
    always @(negedge clk) if (rst_n) begin
        bit sel, wact;
        sel  = !mem_sel_n && mem_sel;
        if (mem_sel_n == mem_sel) mixed = 1;
        wact = sel && !mem_we_n;
        sel_cnt = sel ? sel_cnt + 1 : 0;
        if (sel && !mem_oe_n && mem_we_n) oe_cnt++;
        if (wact) begin
            we_cnt++;
            if (!mem_oe_n) oe_in_wr++;
            if (mem_dq_oe) begin dq_cnt++; last_d = mem_dq_out; last_a = int'(mem_addr); end
            else if (dq_cnt == 0) dq_pre++;
        end
        if (wact_q && !wact) begin
            model_mem[last_a] = last_d;
            check(we_cnt == E_WSTB, "R4 write strobe width", we_cnt, E_WSTB);
            check(oe_in_wr == 0, "R4 oe held high in write", oe_in_wr, 0);
            check(dq_pre == E_DQPRE, "R5 bus drive delay", dq_pre, E_DQPRE);
            check(dq_cnt == E_DQON, "R5 bus drive length", dq_cnt, E_DQON);
            we_cnt = 0; dq_cnt = 0; dq_pre = 0; oe_in_wr = 0;
        end
        if (!sel && oe_cnt != 0) begin
            check(oe_cnt == E_RSTB, "R6 read strobe width", oe_cnt, E_RSTB);
            oe_cnt = 0;
        end
        if (mem_dq_oe && mem_we_n) check(0, "R5 drive without write", 1, 0);
        wact_q = wact;
        mem_dq_in = (sel && !mem_oe_n && mem_we_n && sel_cnt >= 11 && oe_cnt >= 5 &&
                     model_mem.exists(int'(mem_addr))) ? model_mem[int'(mem_addr)] : 8'hA5;
    end

    // Monitor: pop expectation on each ack, compare data, latency, recovery.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                exp_t e;
                int rec;
                acks++;
                if (exp_q.size() == 0) begin
                    check(0, "R2 ack without request", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(cyc - e.acc == (e.wr ? E_WLAT : E_RLAT), "R8 ack latency",
                          cyc - e.acc, e.wr ? E_WLAT : E_RLAT);
                    if (!e.wr) check(rsp_rdata == e.data, "R6 read data", rsp_rdata, e.data);
                    rec = 0;
                    while (!req_ready) begin @(negedge clk); rec++; end
                    check(rec == (e.wr ? E_WREC : E_RREC), "R7 recovery length",
                          rec, e.wr ? E_WREC : E_RREC);
                    check(!rsp_valid || rec == 0, "R8 single-cycle ack", rsp_valid, 0);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
              "R1 strobes in reset", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(mem_sel_n && !mem_sel, "R3 idle deselected", {mem_sel_n, mem_sel}, 2'b10);

        issue(1, 18'h00000, 8'h3C);
        issue(1, 18'h3FFFF, 8'hFF);
        issue(1, 18'h12345, 8'h00);
        issue(0, 18'h00000, 8'h00);
        issue(0, 18'h3FFFF, 8'h00);
        issue(1, 18'h00001, 8'h5A);
        issue(0, 18'h00001, 8'h00);
        issue(0, 18'h12345, 8'h00);
        issue(1, 18'h12345, 8'hC3);
        issue(0, 18'h12345, 8'h00);

        // R2: valid held high across a busy period is taken only once.
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h2AAAA; req_wdata = 8'h96;
        begin
            exp_t e;
            e.wr = 1; e.data = 8'h96; e.acc = cyc + 1;
            gold[int'(18'h2AAAA)] = 8'h96;
            exp_q.push_back(e); reqs++;
        end
        @(negedge clk);
        req_wdata = 8'h11;
        repeat (6) @(negedge clk);
        req_valid = 1'b0;
        issue(0, 18'h2AAAA, 8'h00);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        check(acks == reqs, "R2 one ack per request", acks, reqs);
        check(!mixed, "R3 selects always agree", mixed, 0);
        check(mem_sel_n && !mem_sel && req_ready, "R3 deselected when idle",
              {mem_sel_n, mem_sel, req_ready}, 3'b101);
        done = 1;
        finish_run();
    end

endmodule